// File: doc/BRIEF.md
# Safeload Parameter Transfer Engine

This block sits between a host register port and a parameter RAM that holds 22-bit coefficients at 8-bit addresses. The host fills a small bank of staging slots, each holding one RAM address and one data word. Writing a slot marks it dirty. The host then raises a transfer request, and the engine walks the dirty slots in ascending slot order. It issues one RAM write per clock for each dirty slot and clears that slot's dirty mark. Slots the host has not touched since the last transfer are skipped.

When the last pending slot has been written, the engine raises a completion flag. The flag stays up until the host pulses a status-read strobe. A request made with no dirty slots completes at once. A request made while a transfer is running is ignored.

Staging writes use a valid/ready handshake. Ready is low for the whole transfer, so the host must hold its slot, address and data stable with valid high until it sees ready high. The RAM side is a write-only port with a one-cycle strobe and no back-pressure: the RAM must accept a write on every cycle that the strobe is high. The request, status-read, busy and done pins are plain level or pulse signals.

Top module: `param_stage_uploader`

## Requirements
- R1: After reset, ready is 1, busy is 0, done is 0, the RAM write strobe is 0, and no slot is dirty.
- R2: A staging write is accepted on a clock edge where valid and ready are both 1. It stores the address/data pair in the slot and marks the slot dirty. A slot index of 5 or more is accepted but has no effect.
- R3: Ready is 0 in every cycle in which busy is 1.
- R4: A request taken while idle, with at least one dirty slot, raises busy after that edge. On each later edge the engine writes the lowest-numbered dirty slot to the RAM port, with the strobe, address and data registered. Exactly the dirty slots are written, each once, in ascending slot order.
- R5: Each slot that is uploaded loses its dirty mark. A second request with no new writes produces no RAM write.
- R6: A request taken while idle with no dirty slot produces no RAM write and leaves busy at 0. Done is 1 after that edge.
- R7: Busy drops and done rises on the same edge that registers the last RAM write of a transfer.
- R8: Done stays at 1 until a status-read pulse is taken, and is 0 after that edge. If a completion happens on the same edge as the read, done stays at 1.
- R9: A request taken while busy is 1 has no effect: the transfer writes no extra entries, and nothing follows it.
- R10: Writing a dirty slot again replaces its pair. The slot still produces only one RAM write, which carries the latest values.
- R11: A staging write accepted on the same edge as an idle request is included in that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_valid | input | 1 | Staging write valid |
| host_wr_ready | output | 1 | Staging write ready (0 while transferring) |
| host_wr_slot | input | 3 | Staging slot index |
| host_wr_addr | input | 8 | Parameter RAM address to stage |
| host_wr_data | input | 22 | Parameter data word to stage |
| xfer_req | input | 1 | Transfer request pulse |
| xfer_busy | output | 1 | Transfer in progress |
| stat_rd | input | 1 | Status-read pulse; clears done |
| stat_done | output | 1 | Transfer complete flag |
| ram_we | output | 1 | Parameter RAM write strobe |
| ram_addr | output | 8 | Parameter RAM write address |
| ram_data | output | 22 | Parameter RAM write data |

## Verification
A dirty mark that fails to set, fails to clear, or is left stale shows up in the next transfer's RAM write list. The list is then too short, too long, or out of order, and the error can be seen within one transfer of the fault. A controller stuck in its run state shows ready held low and a RAM strobe that never stops. A misplaced end of transfer shows up as done and busy out of step with the last write, on that very cycle. A done flag that fails to set or clear shows up on the cycle after the request or the read.

// File: rtl/psu_pkg.sv
package psu_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } xfer_state_e;
endpackage

// File: rtl/psu_slot_bank.sv
module psu_slot_bank #(
  parameter int unsigned N  = 5,
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 22,
  parameter int unsigned SW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SW-1:0]        wr_slot,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic                 clr_en,
  input  logic [SW-1:0]        clr_slot,
  output logic [N-1:0]         dirty,
  output logic [N-1:0][AW-1:0] ent_addr,
  output logic [N-1:0][DW-1:0] ent_data
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dirty[g]    <= 1'b0;
        ent_addr[g] <= '0;
        ent_data[g] <= '0;
      end else if (wr_en && wr_slot == SW'(g)) begin
        dirty[g]    <= 1'b1;
        ent_addr[g] <= wr_addr;
        ent_data[g] <= wr_data;
      end else if (clr_en && clr_slot == SW'(g)) begin
        dirty[g]    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/psu_lowest_pick.sv
module psu_lowest_pick #(
  parameter int unsigned N  = 5,
  parameter int unsigned SW = 3
) (
  input  logic [N-1:0]  dirty,
  output logic          found,
  output logic [SW-1:0] idx,
  output logic          more
);
  logic [N-1:0] rest;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (dirty[i]) idx = SW'(i);
    end
  end

  always_comb begin
    rest = dirty;
    for (int i = 0; i < N; i++) begin
      if (SW'(i) == idx) rest[i] = 1'b0;
    end
  end

  assign found = |dirty;
  assign more  = |rest;
endmodule

// File: rtl/psu_xfer_ctrl.sv
module psu_xfer_ctrl
  import psu_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 22,
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfer_req,
  input  logic          pend_any,
  input  logic          sel_found,
  input  logic [SW-1:0] sel_idx,
  input  logic          sel_more,
  input  logic [AW-1:0] sel_addr,
  input  logic [DW-1:0] sel_data,
  input  logic          stat_rd,
  output logic          busy,
  output logic          clr_en,
  output logic [SW-1:0] clr_slot,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_data,
  output logic          stat_done
);
  xfer_state_e state;
  logic        done_set;

  assign busy     = (state == ST_RUN);
  assign clr_en   = busy && sel_found;
  assign clr_slot = sel_idx;

  // Completion: empty request while idle, or last entry leaving while running.
  always_comb begin
    done_set = 1'b0;
    if (state == ST_IDLE) done_set = xfer_req && !pend_any;
    else                  done_set = !sel_found || !sel_more;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ram_we   <= 1'b0;
      ram_addr <= '0;
      ram_data <= '0;
    end else begin
      ram_we <= 1'b0;
      unique case (state)
        ST_IDLE: if (xfer_req && pend_any) state <= ST_RUN;
        ST_RUN: begin
          if (sel_found) begin
            ram_we   <= 1'b1;
            ram_addr <= sel_addr;
            ram_data <= sel_data;
          end
          if (done_set) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Set wins over the read-clear so a fresh completion is never lost.
  always_ff @(posedge clk) begin
    if (!rst_n)        stat_done <= 1'b0;
    else if (done_set) stat_done <= 1'b1;
    else if (stat_rd)  stat_done <= 1'b0;
  end
endmodule

// File: rtl/param_stage_uploader.sv
module param_stage_uploader #(
  parameter int unsigned NUM_SLOTS = 5,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 22,
  localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_valid,
  output logic              host_wr_ready,
  input  logic [SLOT_W-1:0] host_wr_slot,
  input  logic [ADDR_W-1:0] host_wr_addr,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic              xfer_req,
  output logic              xfer_busy,
  input  logic              stat_rd,
  output logic              stat_done,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_data
);
  logic [NUM_SLOTS-1:0]             dirty;
  logic [NUM_SLOTS-1:0][ADDR_W-1:0] ent_addr;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] ent_data;
  logic                             wr_en;
  logic                             clr_en;
  logic [SLOT_W-1:0]                clr_slot;
  logic                             sel_found;
  logic                             sel_more;
  logic [SLOT_W-1:0]                sel_idx;
  logic                             pend_any;

  assign host_wr_ready = !xfer_busy;
  assign wr_en    = host_wr_valid && host_wr_ready &&
                    (32'(host_wr_slot) < NUM_SLOTS);
  assign pend_any = (|dirty) || wr_en;

  psu_slot_bank #(
    .N (NUM_SLOTS), .AW(ADDR_W), .DW(DATA_W), .SW(SLOT_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_slot (host_wr_slot),
    .wr_addr (host_wr_addr),
    .wr_data (host_wr_data),
    .clr_en  (clr_en),
    .clr_slot(clr_slot),
    .dirty   (dirty),
    .ent_addr(ent_addr),
    .ent_data(ent_data)
  );

  psu_lowest_pick #(.N(NUM_SLOTS), .SW(SLOT_W)) u_pick (
    .dirty(dirty),
    .found(sel_found),
    .idx  (sel_idx),
    .more (sel_more)
  );

  psu_xfer_ctrl #(.AW(ADDR_W), .DW(DATA_W), .SW(SLOT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .xfer_req (xfer_req),
    .pend_any (pend_any),
    .sel_found(sel_found),
    .sel_idx  (sel_idx),
    .sel_more (sel_more),
    .sel_addr (ent_addr[sel_idx]),
    .sel_data (ent_data[sel_idx]),
    .stat_rd  (stat_rd),
    .busy     (xfer_busy),
    .clr_en   (clr_en),
    .clr_slot (clr_slot),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .ram_data (ram_data),
    .stat_done(stat_done)
  );
endmodule

// File: rtl/psu_checker.sv
module psu_checker (
  input logic clk,
  input logic rst_n,
  input logic host_wr_ready,
  input logic xfer_req,
  input logic xfer_busy,
  input logic stat_rd,
  input logic stat_done,
  input logic ram_we
);
  // R3: back-pressure during a transfer
  p_ready_low_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |-> !host_wr_ready);

  // R4: every running cycle yields a RAM write on the next cycle
  p_write_per_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |=> ram_we);

  // R4: RAM writes only follow a running cycle
  p_write_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(xfer_busy));

  // R6: an idle request either starts a run or completes at once
  p_idle_req_acts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_busy && xfer_req) |=> (xfer_busy || stat_done));

  // R7: end of a run raises done together with the last write
  p_end_sets_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_busy) |-> (stat_done && ram_we));

  // R8: a read with no completion clears done
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_done && stat_rd && !xfer_busy && !xfer_req) |=> !stat_done);
endmodule

bind param_stage_uploader psu_checker u_psu_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_wr_ready(host_wr_ready),
  .xfer_req     (xfer_req),
  .xfer_busy    (xfer_busy),
  .stat_rd      (stat_rd),
  .stat_done    (stat_done),
  .ram_we       (ram_we)
);

// File: tb/test_param_stage_uploader.sv
module test_param_stage_uploader;
  localparam int NS = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_valid = 1'b0;
  logic        host_wr_ready;
  logic [2:0]  host_wr_slot = '0;
  logic [7:0]  host_wr_addr = '0;
  logic [21:0] host_wr_data = '0;
  logic        xfer_req = 1'b0;
  logic        xfer_busy;
  logic        stat_rd = 1'b0;
  logic        stat_done;
  logic        ram_we;
  logic [7:0]  ram_addr;
  logic [21:0] ram_data;

  param_stage_uploader i_param_stage_uploader (.*);

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [7:0]  m_addr  [NS];
  logic [21:0] m_data  [NS];
  logic        m_dirty [NS];
  logic [7:0]  e_addr [16];
  logic [21:0] e_data [16];
  int          e_n;
  logic [7:0]  c_addr [16];
  logic [21:0] c_data [16];
  int          c_n = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && ram_we && c_n < 16) begin
      c_addr[c_n] = ram_addr;
      c_data[c_n] = ram_data;
      c_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void model_write(input int s, input logic [7:0] a,
                                      input logic [21:0] d);
    if (s < NS) begin
      m_addr[s] = a; m_data[s] = d; m_dirty[s] = 1'b1;
    end
  endfunction

  function automatic void build_expect();
    e_n = 0;
    for (int s = 0; s < NS; s++) begin
      if (m_dirty[s]) begin
        e_addr[e_n] = m_addr[s]; e_data[e_n] = m_data[s]; e_n++;
        m_dirty[s] = 1'b0;
      end
    end
  endfunction

  task automatic host_write(input int s, input logic [7:0] a, input logic [21:0] d);
    host_wr_valid = 1'b1; host_wr_slot = 3'(s); host_wr_addr = a; host_wr_data = d;
    @(negedge clk);
    host_wr_valid = 1'b0;
    model_write(s, a, d);
  endtask

  task automatic compare_list(input string req);
    chk(c_n == e_n, req, c_n, e_n);
    for (int i = 0; i < e_n && i < c_n; i++) begin
      chk(c_addr[i] == e_addr[i], req, c_addr[i], e_addr[i]);
      chk(c_data[i] == e_data[i], req, c_data[i], e_data[i]);
    end
  endtask

  task automatic wait_idle();
    while (xfer_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_xfer(input string req);
    build_expect();
    c_n = 0;
    xfer_req = 1'b1;
    @(negedge clk);
    xfer_req = 1'b0;
    if (e_n == 0) begin
      chk(!xfer_busy && stat_done && !ram_we, "R6", {xfer_busy, stat_done, ram_we}, 3'b010);
    end else begin
      chk(xfer_busy && !ram_we, "R4", {xfer_busy, ram_we}, 2'b10);
    end
    wait_idle();
    compare_list(req);
    chk(stat_done, "R7", stat_done, 1);
  endtask

  task automatic read_status();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    chk(!stat_done, "R8", stat_done, 0);
  endtask

  initial begin
    void'($urandom(32'h1953_5afe));
    for (int s = 0; s < NS; s++) begin
      m_addr[s] = '0; m_data[s] = '0; m_dirty[s] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(host_wr_ready && !xfer_busy && !stat_done && !ram_we, "R1",
        {host_wr_ready, xfer_busy, stat_done, ram_we}, 4'b1000);
    run_xfer("R1");
    read_status();

    // R4 / R7 cycle-exact: slots 0 and 2
    host_write(2, 8'h21, 22'h2AAAA);
    host_write(0, 8'h05, 22'h15555);
    build_expect();
    c_n = 0;
    xfer_req = 1'b1;
    @(negedge clk);
    xfer_req = 1'b0;
    chk(xfer_busy && !ram_we && !stat_done, "R4", {xfer_busy, ram_we, stat_done}, 3'b100);
    @(negedge clk);
    chk(ram_we && ram_addr == 8'h05 && xfer_busy, "R4", {ram_we, ram_addr}, {1'b1, 8'h05});
    chk(!host_wr_ready, "R3", host_wr_ready, 0);
    @(negedge clk);
    chk(ram_we && ram_addr == 8'h21 && !xfer_busy && stat_done, "R7",
        {ram_we, xfer_busy, stat_done, ram_addr}, {3'b101, 8'h21});
    @(negedge clk);
    compare_list("R4");
    // R8 done holds until read
    repeat (3) @(negedge clk);
    chk(stat_done, "R8", stat_done, 1);
    read_status();

    // R5 second request with nothing new
    run_xfer("R5");
    read_status();

    // R2 out-of-range slots have no effect
    host_write(5, 8'hF5, 22'h1);
    host_write(7, 8'hF7, 22'h2);
    run_xfer("R2");
    read_status();

    // R10 overwrite before transfer
    host_write(3, 8'h30, 22'h00111);
    host_write(3, 8'h31, 22'h00222);
    run_xfer("R10");
    chk(c_n == 1, "R10", c_n, 1);

    // R8 completion on same edge as read keeps done
    read_status();
    stat_rd = 1'b1; xfer_req = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0; xfer_req = 1'b0;
    chk(stat_done, "R8", stat_done, 1);
    read_status();

    // R11 write on the same edge as request
    host_wr_valid = 1'b1; host_wr_slot = 3'd4; host_wr_addr = 8'h44; host_wr_data = 22'h3C3C3;
    xfer_req = 1'b1;
    model_write(4, 8'h44, 22'h3C3C3);
    build_expect();
    c_n = 0;
    @(negedge clk);
    host_wr_valid = 1'b0; xfer_req = 1'b0;
    wait_idle();
    compare_list("R11");
    read_status();

    // R9 request while busy is ignored; R3 ready low
    for (int s = 0; s < NS; s++) host_write(s, 8'(8'h80 + s), 22'(s * 7 + 1));
    build_expect();
    c_n = 0;
    xfer_req = 1'b1;
    @(negedge clk);
    chk(xfer_busy, "R9", xfer_busy, 1);
    @(negedge clk);
    chk(!host_wr_ready, "R3", host_wr_ready, 0);
    @(negedge clk);
    xfer_req = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    compare_list("R9");
    chk(!xfer_busy, "R9", xfer_busy, 0);
    read_status();

    // Random rounds
    for (int r = 0; r < 40; r++) begin
      int nw;
      nw = $urandom_range(0, 7);
      for (int k = 0; k < nw; k++)
        host_write($urandom_range(0, 7), 8'($urandom), 22'($urandom));
      if ($urandom_range(0, 1) == 1) read_status();
      run_xfer("R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule